// File: doc/BRIEF.md
# Five-Stage In-Order Load/Store Pipeline Core

This block is a small in-order processor core that runs a 16-bit load/store instruction stream through five stages. The stages are fetch, decode with register read, execute, data-memory access and register write-back. Instruction memory and data memory are separate, and each is reached over its own combinational-read port. A data-memory write is committed at the clock edge that closes the memory stage. The register file is exposed as one flat vector so that its contents can be observed.

The register file has a single access slot per cycle. In one cycle it either serves both operand reads of the instruction in decode or takes the write from write-back, never both. The write always wins. The instruction in decode then waits, the fetch side holds, and execute receives a bubble. The core has no forwarding. A read-after-write dependence holds decode until the producing instruction has been written back.

Top module: `lsp_core`

## Requirements
- R1: While reset is low, and before the first clock edge after it is released, `imem_addr_o` is 0, `dmem_we_o` is 0, and every register in `rf_o` is 0. All pipeline stages hold no-operations.
- R2: Instruction word layout: opcode in bits [15:12], destination in [11:9], first source in [8:6], second source in [5:3], and a zero-extended offset in [2:0]. Opcode codes: 0 no-op, 1 add, 2 subtract, 3 AND, 4 OR, 5 load, 6 store.
- R3: Opcodes 1–4 write `rs1 op rs2`, computed modulo 2^16, into `rd`.
- R4: A load writes `dmem[rs1 + off]` into `rd`.
- R5: A store writes `rs2` to `dmem[rs1 + off]`. With no stall, `dmem_we_o` is high in the cycle after the third clock edge following the store's fetch cycle.
- R6: ALU and load instructions never raise `dmem_we_o`.
- R7: `imem_addr_o` advances by exactly one per cycle unless decode is stalled, and is held during a stall.
- R8: When a register write-back falls in the same cycle as a decode that needs operands, the decode is delayed by one cycle. This shifts a following store's memory cycle, and `imem_addr_o`, by one cycle.
- R9: A decode whose source register matches a pending destination in execute, memory or write-back waits until that value is written, and then reads the new value.
- R10: The register file never performs a read and a write in the same cycle.
- R11: Opcodes 7–15 act as no-ops: they change no register, raise no write enable and cause no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | ADDR_W | Instruction fetch address (PC) |
| imem_data_i | input | 16 | Instruction word at `imem_addr_o` |
| dmem_addr_o | output | ADDR_W | Data memory address of the memory stage |
| dmem_we_o | output | 1 | Data memory write enable |
| dmem_wdata_o | output | DATA_W | Store data |
| dmem_rdata_i | input | DATA_W | Load data at `dmem_addr_o` |
| rf_o | output | 8*DATA_W | Register file, register n at bits [n*DATA_W +: DATA_W] |

## Verification
A wrong stall decision shows up at the ports within a few cycles. A missed stall lets a store write stale register data, and the wrong value appears on `dmem_wdata_o` in the store's own memory cycle. An extra or missing stall shifts `dmem_we_o` and `imem_addr_o` by one cycle against the predicted schedule. A corrupted operand or ALU path is seen in `rf_o` and in data memory once the dependent chain drains, about a dozen cycles after fetch.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int unsigned IW = 16;
  localparam int unsigned RW = 3;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3,
    OP_OR  = 4'd4, OP_LD  = 4'd5, OP_ST  = 4'd6
  } op_e;

  typedef struct packed {
    op_e           op;
    logic [RW-1:0] rd;
    logic [RW-1:0] rs1;
    logic [RW-1:0] rs2;
    logic [RW-1:0] off;
    logic          wr_rd;
    logic          use_a;
    logic          use_b;
  } dec_t;

  typedef struct packed {
    op_e           op;
    logic          wr;
    logic [RW-1:0] rd;
  } tag_t;

  function automatic dec_t decode(logic [IW-1:0] w);
    dec_t d;
    d.rd    = w[11:9];
    d.rs1   = w[8:6];
    d.rs2   = w[5:3];
    d.off   = w[2:0];
    d.op    = OP_NOP;
    d.wr_rd = 1'b0;
    d.use_a = 1'b0;
    d.use_b = 1'b0;
    case (w[15:12])
      4'd1: begin d.op = OP_ADD; d.wr_rd = 1'b1; d.use_a = 1'b1; d.use_b = 1'b1; end
      4'd2: begin d.op = OP_SUB; d.wr_rd = 1'b1; d.use_a = 1'b1; d.use_b = 1'b1; end
      4'd3: begin d.op = OP_AND; d.wr_rd = 1'b1; d.use_a = 1'b1; d.use_b = 1'b1; end
      4'd4: begin d.op = OP_OR;  d.wr_rd = 1'b1; d.use_a = 1'b1; d.use_b = 1'b1; end
      4'd5: begin d.op = OP_LD;  d.wr_rd = 1'b1; d.use_a = 1'b1; end
      4'd6: begin d.op = OP_ST;  d.use_a = 1'b1; d.use_b = 1'b1; end
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/lsp_regfile.sv
module lsp_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREG   = 8,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic                   rd_en_i,
  input  logic [AW-1:0]          rd_addr_a_i,
  input  logic [AW-1:0]          rd_addr_b_i,
  output logic [DATA_W-1:0]      rd_a_o,
  output logic [DATA_W-1:0]      rd_b_o,
  output logic [NREG*DATA_W-1:0] flat_o
);
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en_i) begin
      regs[wr_addr_i] <= wr_data_i;
    end
  end

  // single slot: a write owns the port
  wire rd_grant = rd_en_i && !wr_en_i;
  assign rd_a_o = rd_grant ? regs[rd_addr_a_i] : '0;
  assign rd_b_o = rd_grant ? regs[rd_addr_b_i] : '0;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign flat_o[g*DATA_W +: DATA_W] = regs[g];
  end

  AST_ONE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rd_en_i)); // R10
endmodule

// File: rtl/lsp_hazard.sv
module lsp_hazard import lsp_pkg::*; #(
  parameter int unsigned NPROD = 3
) (
  input  dec_t                     id_i,
  input  logic [NPROD-1:0]         prod_wr_i,
  input  logic [NPROD-1:0][RW-1:0] prod_rd_i,
  input  logic                     wb_busy_i,
  output logic                     stall_o
);
  logic raw;
  always_comb begin
    raw = 1'b0;
    for (int k = 0; k < NPROD; k++) begin
      if (prod_wr_i[k] && ((id_i.use_a && prod_rd_i[k] == id_i.rs1) ||
                           (id_i.use_b && prod_rd_i[k] == id_i.rs2)))
        raw = 1'b1;
    end
  end
  assign stall_o = (id_i.use_a || id_i.use_b) && (raw || wb_busy_i);
endmodule

// File: rtl/lsp_alu.sv
module lsp_alu import lsp_pkg::*; #(
  parameter int unsigned DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [RW-1:0]     off_i,
  output logic [DATA_W-1:0] c_o
);
  always_comb begin
    case (op_i)
      OP_ADD:       c_o = a_i + b_i;
      OP_SUB:       c_o = a_i - b_i;
      OP_AND:       c_o = a_i & b_i;
      OP_OR:        c_o = a_i | b_i;
      OP_LD, OP_ST: c_o = a_i + DATA_W'(off_i);
      default:      c_o = '0;
    endcase
  end
endmodule

// File: rtl/lsp_core.sv
module lsp_core import lsp_pkg::*; #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned NREG  = 1 << RW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  output logic [ADDR_W-1:0]      imem_addr_o,
  input  logic [IW-1:0]          imem_data_i,
  output logic [ADDR_W-1:0]      dmem_addr_o,
  output logic                   dmem_we_o,
  output logic [DATA_W-1:0]      dmem_wdata_o,
  input  logic [DATA_W-1:0]      dmem_rdata_i,
  output logic [NREG*DATA_W-1:0] rf_o
);
  localparam tag_t NOP_TAG = '{op: OP_NOP, wr: 1'b0, rd: '0};

  logic [ADDR_W-1:0] pc;
  logic [IW-1:0]     ir;
  dec_t              id_dec;
  logic              stall, rf_rd_en;
  logic [DATA_W-1:0] rf_a, rf_b;

  tag_t              ex_tag, mem_tag;
  logic [DATA_W-1:0] ex_a, ex_b, alu_c, mem_c, mem_sd, wb_val;
  logic [RW-1:0]     ex_off, wb_rd;
  logic              wb_wr;

  // fetch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc <= '0;
      ir <= '0;
    end else if (!stall) begin
      pc <= pc + 1'b1;
      ir <= imem_data_i;
    end
  end
  assign imem_addr_o = pc;

  // decode / operand fetch
  assign id_dec   = decode(ir);
  assign rf_rd_en = (id_dec.use_a || id_dec.use_b) && !stall;

  lsp_hazard #(.NPROD(3)) u_hazard (
    .id_i      (id_dec),
    .prod_wr_i ({wb_wr, mem_tag.wr, ex_tag.wr}),
    .prod_rd_i ({wb_rd, mem_tag.rd, ex_tag.rd}),
    .wb_busy_i (wb_wr),
    .stall_o   (stall)
  );

  lsp_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wb_wr),
    .wr_addr_i   (wb_rd),
    .wr_data_i   (wb_val),
    .rd_en_i     (rf_rd_en),
    .rd_addr_a_i (id_dec.rs1),
    .rd_addr_b_i (id_dec.rs2),
    .rd_a_o      (rf_a),
    .rd_b_o      (rf_b),
    .flat_o      (rf_o)
  );

  // execute
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_tag <= NOP_TAG;
      ex_a   <= '0;
      ex_b   <= '0;
      ex_off <= '0;
    end else begin
      ex_tag <= stall ? NOP_TAG : '{op: id_dec.op, wr: id_dec.wr_rd, rd: id_dec.rd};
      ex_a   <= rf_a;
      ex_b   <= rf_b;
      ex_off <= id_dec.off;
    end
  end

  lsp_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (ex_tag.op),
    .a_i   (ex_a),
    .b_i   (ex_b),
    .off_i (ex_off),
    .c_o   (alu_c)
  );

  // memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_tag <= NOP_TAG;
      mem_c   <= '0;
      mem_sd  <= '0;
    end else begin
      mem_tag <= ex_tag;
      mem_c   <= alu_c;
      mem_sd  <= ex_b;
    end
  end
  assign dmem_addr_o  = mem_c[ADDR_W-1:0];
  assign dmem_we_o    = (mem_tag.op == OP_ST);
  assign dmem_wdata_o = mem_sd;

  // write-back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_wr  <= 1'b0;
      wb_rd  <= '0;
      wb_val <= '0;
    end else begin
      wb_wr  <= mem_tag.wr;
      wb_rd  <= mem_tag.rd;
      wb_val <= (mem_tag.op == OP_LD) ? dmem_rdata_i : mem_c;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall |=> pc == ADDR_W'($past(pc) + 1'b1)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> $stable(pc) && $stable(ir)); // R8
  AST_STALL_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> ex_tag.op == OP_NOP && !ex_tag.wr); // R8
  AST_RAW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_rd_en |-> !((ex_tag.wr  && ((id_dec.use_a && ex_tag.rd  == id_dec.rs1) || (id_dec.use_b && ex_tag.rd  == id_dec.rs2))) ||
                   (mem_tag.wr && ((id_dec.use_a && mem_tag.rd == id_dec.rs1) || (id_dec.use_b && mem_tag.rd == id_dec.rs2))) ||
                   (wb_wr      && ((id_dec.use_a && wb_rd      == id_dec.rs1) || (id_dec.use_b && wb_rd      == id_dec.rs2))))); // R9
  AST_STORE_ONLY_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> !mem_tag.wr); // R6
endmodule

// File: tb/lsp_core_test.sv
module lsp_core_test;
  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] imem_addr, dmem_addr;
  logic [15:0]   imem_data;
  logic          dmem_we;
  logic [DW-1:0] dmem_wdata, dmem_rdata;
  logic [8*DW-1:0] rf;

  logic [15:0] imem [32];
  logic [15:0] dmem [16];
  logic [15:0] dmem_init [16];

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  lsp_core #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_we_o(dmem_we),
    .dmem_wdata_o(dmem_wdata), .dmem_rdata_i(dmem_rdata),
    .rf_o(rf)
  );

  assign imem_data  = imem[imem_addr[4:0]];
  assign dmem_rdata = dmem[dmem_addr[3:0]];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) dmem <= dmem_init;
    else if (dmem_we) dmem[dmem_addr[3:0]] <= dmem_wdata;
  end

  // 250 MHz: 4 ns period
  localparam logic [51:0] VECS [6] = '{
    {4'd1, 16'h1234, 16'h0F0F, 16'h2143},
    {4'd2, 16'h0005, 16'h0007, 16'hFFFE},
    {4'd3, 16'hF0F0, 16'h3C3C, 16'h3030},
    {4'd4, 16'h1200, 16'h0034, 16'h1234},
    {4'd1, 16'hFFFF, 16'h0002, 16'h0001},
    {4'd2, 16'h8000, 16'h0001, 16'h7FFF}
  };

  function automatic logic [15:0] enc(logic [3:0] op, logic [2:0] rd, logic [2:0] a,
                                      logic [2:0] b, logic [2:0] off);
    return {op, rd, a, b, off};
  endfunction

  function automatic logic [15:0] reg_of(int n);
    return rf[n*DW +: DW];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) imem[i] = 16'h0000;
    for (int i = 0; i < 16; i++) dmem_init[i] = 16'h0000;
  endtask

  // hold reset one edge, release at negedge: next posedge is edge 1
  task automatic restart();
    @(negedge clk);
    rst_ni = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    clear_mem();
    imem[0] = enc(4'd1, 3'd1, 3'd0, 3'd0, 3'd0);
    restart();
    #1;
    chk("R1 pc", 32'(imem_addr), 32'd0);
    chk("R1 we", 32'(dmem_we), 32'd0);
    chk("R1 regs", 32'(rf == '0), 32'd1);

    // R2 R3 R4 R5 R9: vector table, load a/b, operate, store result
    foreach (VECS[v]) begin
      clear_mem();
      dmem_init[0] = VECS[v][47:32];
      dmem_init[1] = VECS[v][31:16];
      imem[0] = enc(4'd5, 3'd1, 3'd0, 3'd0, 3'd0);
      imem[1] = enc(4'd5, 3'd2, 3'd0, 3'd0, 3'd1);
      imem[2] = enc(VECS[v][51:48], 3'd3, 3'd1, 3'd2, 3'd0);
      imem[3] = enc(4'd6, 3'd0, 3'd0, 3'd3, 3'd2);
      restart();
      edges(20);
      chk($sformatf("R3 R2 vec%0d r3", v), 32'(reg_of(3)), 32'(VECS[v][15:0]));
      chk($sformatf("R4 vec%0d r1", v), 32'(reg_of(1)), 32'(VECS[v][47:32]));
      chk($sformatf("R5 R9 vec%0d mem2", v), 32'(dmem[2]), 32'(VECS[v][15:0]));
    end

    // R4: base plus offset addressing
    clear_mem();
    dmem_init[0] = 16'h0002;
    dmem_init[6] = 16'h00AB;
    imem[0] = enc(4'd5, 3'd1, 3'd0, 3'd0, 3'd0);
    imem[1] = enc(4'd5, 3'd5, 3'd1, 3'd0, 3'd4);
    restart();
    edges(16);
    chk("R4 base+off", 32'(reg_of(5)), 32'h00AB);

    // R7: pc steps with no-ops
    clear_mem();
    restart();
    edges(3);
    chk("R7 pc", 32'(imem_addr), 32'd3);

    // R5: store timing, no stall
    clear_mem();
    imem[0] = enc(4'd6, 3'd0, 3'd0, 3'd0, 3'd5);
    restart();
    edges(2);
    chk("R5 we early", 32'(dmem_we), 32'd0);
    edges(1);
    chk("R5 we", 32'(dmem_we), 32'd1);
    chk("R5 addr", 32'(dmem_addr), 32'd5);

    // R6: ALU and load never write memory
    clear_mem();
    imem[0] = enc(4'd1, 3'd1, 3'd0, 3'd0, 3'd0);
    imem[1] = enc(4'd5, 3'd2, 3'd0, 3'd0, 3'd0);
    imem[2] = enc(4'd4, 3'd3, 3'd1, 3'd2, 3'd0);
    restart();
    begin
      int seen = 0;
      for (int c = 0; c < 14; c++) begin
        edges(1);
        if (dmem_we) seen++;
      end
      chk("R6 no we", 32'(seen), 32'd0);
    end

    // R8 R10: write-back collides with store decode
    clear_mem();
    imem[0] = enc(4'd5, 3'd1, 3'd0, 3'd0, 3'd0);
    imem[3] = enc(4'd6, 3'd0, 3'd0, 3'd0, 3'd4);
    restart();
    edges(5);
    chk("R8 pc held", 32'(imem_addr), 32'd4);
    edges(1);
    chk("R8 R10 we delayed", 32'(dmem_we), 32'd0);
    edges(1);
    chk("R8 R10 we", 32'(dmem_we), 32'd1);
    chk("R8 addr", 32'(dmem_addr), 32'd4);

    // R9: store depends on the load just before it
    clear_mem();
    dmem_init[0] = 16'h5A5A;
    imem[0] = enc(4'd5, 3'd1, 3'd0, 3'd0, 3'd0);
    imem[1] = enc(4'd6, 3'd0, 3'd0, 3'd1, 3'd4);
    restart();
    edges(6);
    chk("R9 we held", 32'(dmem_we), 32'd0);
    edges(1);
    chk("R9 we", 32'(dmem_we), 32'd1);
    chk("R9 wdata", 32'(dmem_wdata), 32'h5A5A);

    // R11: undefined opcodes do nothing
    clear_mem();
    imem[0] = enc(4'hF, 3'd5, 3'd0, 3'd0, 3'd0);
    imem[1] = enc(4'h8, 3'd6, 3'd0, 3'd0, 3'd1);
    imem[2] = enc(4'h7, 3'd7, 3'd0, 3'd0, 3'd0);
    restart();
    begin
      int seen = 0;
      for (int c = 0; c < 10; c++) begin
        edges(1);
        if (dmem_we) seen++;
      end
      chk("R11 no we", 32'(seen), 32'd0);
      chk("R11 no stall", 32'(imem_addr), 32'd10);
      chk("R11 regs", 32'(rf == '0), 32'd1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule